// File: doc/BRIEF.md
# Cache Event Counter Bank

This block is a bank of programmable event counters for a private second-level cache. Each counter has its own event selector. A selector names one of four event groups in its low byte and holds a mask of that group's events above it. In any clock where at least one masked event of the chosen group pulses, the counter advances by one. One counter can therefore follow one event, or the union of several events from the same group.

Software reaches the selectors and counters through a 32-bit register port. Each 64-bit register takes two word accesses: the low word sits at the register's offset and the high word sits four bytes above it. A counter is stopped by clearing its selector. It is restarted by writing zero to the counter and then programming the selector again. Read data is registered and appears on the clock after the read request. The event pulse vectors come from the cache pipeline, one bit per event per cycle.

Top module: `cpc_bank`

## Requirements
- R1: Reset clears every selector and every counter, so each of them reads back as zero.
- R2: Selector n occupies byte offsets 0x2000+8n (bits 31:0) and 0x2004+8n (bits 63:32). Counter n occupies 0x3000+8n (low) and 0x3004+8n (high), with n from 0 to 63. A selector reads back the value last written to it.
- R3: Selector bits 7:0 give the group number: 1, 2, 3 or 4. Selector bit 8+k enables event k of that group, and event k is bit k of that group's event input. The groups have 20, 19, 14 and 1 events in that order.
- R4: In a cycle where one or more enabled events of the selected group pulse, the counter increases by exactly one, however many of those events pulse together.
- R5: A counter whose selector is zero, or whose group number is 0 or above 4, does not change.
- R6: A selector with any mask bit set at or above its group's event count counts nothing, even when its in-range events pulse.
- R7: Events of groups other than the selected one have no effect on a counter.
- R8: Writing one half of a counter replaces that half and leaves the other half unchanged.
- R9: When the bus writes a counter in the same cycle that an event would advance it, the written value is kept and that cycle's increment is lost.
- R10: A counter wraps modulo 2^64. A carry out of the low word reaches the high word.
- R11: Any access that does not hit one of the defined aligned registers reads as zero and writes nothing. This covers addresses outside both windows and addresses with bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| grp1_ev | input | 20 | Per-cycle event pulses of group 1 |
| grp2_ev | input | 19 | Per-cycle event pulses of group 2 |
| grp3_ev | input | 14 | Per-cycle event pulses of group 3 |
| grp4_ev | input | 1 | Per-cycle event pulses of group 4 |

## Verification
The counters are driven by one shared sequence of event bursts while several selectors are live at once. A counter that is tracking one event, one that tracks the union of two events, and one that tracks the only event of the single-event group each accumulate a different total from the same sequence. This shows that group and mask decoding are per counter. The sequence also includes bursts on unselected events of the chosen group, bursts on other groups, and bursts where every event of a group fires together. These separate "any selected event" from "sum of events" and from leakage between groups. Invalid selectors see the same bursts and must stay at zero. A further set of stimuli tests the edge cases: counters preloaded near all ones, to show the wrap and the carry between words; a bus write that lands in the same cycle as an event; and accesses that are misaligned or fall outside the windows.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    parameter int N_CNT   = 64;
    parameter int CNT_W   = 64;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 14;
    parameter int GRP_W   = 8;
    parameter int N_GRP   = 4;
    parameter int MAX_EV  = 20;
    parameter logic [ADDR_W-1:0] SEL_BASE = 14'h2000;
    parameter logic [ADDR_W-1:0] CNT_BASE = 14'h3000;

    localparam int IDX_W   = $clog2(N_CNT);
    localparam int MASK_W  = CNT_W - GRP_W;
    localparam int SPAN    = N_CNT * 8;
    localparam int EVALL_W = N_GRP * MAX_EV;

    function automatic int grp_size(input int g);
        case (g)
            1:       return 20;
            2:       return 19;
            3:       return 14;
            4:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [MASK_W-1:0] grp_mask(input int g);
        return (MASK_W'(1) << grp_size(g)) - MASK_W'(1);
    endfunction

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SEL  = 2'd1,
        REG_CNT  = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } dec_t;
endpackage

// File: rtl/cpc_addr_dec.sv
module cpc_addr_dec
    import cpc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [ADDR_W-1:0] rel_sel_d;
    logic [ADDR_W-1:0] rel_cnt_d;

    always_comb begin
        dec       = '0;
        rel_sel_d = addr - SEL_BASE;
        rel_cnt_d = addr - CNT_BASE;
        if (addr[1:0] == 2'b00) begin
            if (addr >= SEL_BASE && 32'(addr) < 32'(SEL_BASE) + SPAN) begin
                dec.kind = REG_SEL;
                dec.idx  = rel_sel_d[3 +: IDX_W];
                dec.hi   = addr[2];
            end else if (addr >= CNT_BASE && 32'(addr) < 32'(CNT_BASE) + SPAN) begin
                dec.kind = REG_CNT;
                dec.idx  = rel_cnt_d[3 +: IDX_W];
                dec.hi   = addr[2];
            end
        end
    end
endmodule

// File: rtl/cpc_event_match.sv
module cpc_event_match
    import cpc_pkg::*;
(
    input  logic [CNT_W-1:0]   sel,
    input  logic [EVALL_W-1:0] ev_all,
    output logic               hit
);
    logic [GRP_W-1:0]  grp_d;
    logic [MASK_W-1:0] mask_d;

    always_comb begin
        grp_d  = sel[GRP_W-1:0];
        mask_d = sel[CNT_W-1:GRP_W];
        hit    = 1'b0;
        for (int g = 1; g <= N_GRP; g++) begin
            if (grp_d == GRP_W'(g) && (mask_d & ~grp_mask(g)) == '0) begin
                hit = |(mask_d[MAX_EV-1:0] & ev_all[(g-1)*MAX_EV +: MAX_EV]);
            end
        end
    end
endmodule

// File: rtl/cpc_bank.sv
module cpc_bank
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [13:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [19:0]       grp1_ev,
    input  logic [18:0]       grp2_ev,
    input  logic [13:0]       grp3_ev,
    input  logic [0:0]        grp4_ev
);
    typedef struct packed {
        logic [N_CNT-1:0][CNT_W-1:0] sel;
        logic [N_CNT-1:0][CNT_W-1:0] cnt;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t             st_d, st_q;
    dec_t               dec;
    logic [EVALL_W-1:0] ev_all;
    logic [N_CNT-1:0]   hit;
    logic [N_CNT-1:0]   cnt_wr_d;
    logic [N_CNT-1:0]   sel_wr_d;
    logic               wr_d, rd_d;

    assign ev_all = {19'b0, grp4_ev, 6'b0, grp3_ev, 1'b0, grp2_ev, grp1_ev};

    cpc_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_match
        cpc_event_match u_match (
            .sel    (st_q.sel[i]),
            .ev_all (ev_all),
            .hit    (hit[i])
        );
    end

    always_comb begin
        st_d = st_q;
        wr_d = bus_en && bus_we;
        rd_d = bus_en && !bus_we;
        for (int i = 0; i < N_CNT; i++) begin
            cnt_wr_d[i] = wr_d && dec.kind == REG_CNT && dec.idx == IDX_W'(i);
            sel_wr_d[i] = wr_d && dec.kind == REG_SEL && dec.idx == IDX_W'(i);
            if (cnt_wr_d[i]) begin
                if (dec.hi) st_d.cnt[i][CNT_W-1:DATA_W] = bus_wdata;
                else        st_d.cnt[i][DATA_W-1:0]     = bus_wdata;
            end else if (hit[i]) begin
                st_d.cnt[i] = st_q.cnt[i] + CNT_W'(1);
            end
            if (sel_wr_d[i]) begin
                if (dec.hi) st_d.sel[i][CNT_W-1:DATA_W] = bus_wdata;
                else        st_d.sel[i][DATA_W-1:0]     = bus_wdata;
            end
        end
        if (rd_d) begin
            case (dec.kind)
                REG_SEL: st_d.rdata = dec.hi ? st_q.sel[dec.idx][CNT_W-1:DATA_W]
                                             : st_q.sel[dec.idx][DATA_W-1:0];
                REG_CNT: st_d.rdata = dec.hi ? st_q.cnt[dec.idx][CNT_W-1:DATA_W]
                                             : st_q.cnt[dec.idx][DATA_W-1:0];
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && dec.kind == REG_NONE) |=> bus_rdata == '0);

    for (genvar i = 0; i < N_CNT; i++) begin : g_chk
        // R5
        idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.sel[i] == '0 && !cnt_wr_d[i]) |=> $stable(st_q.cnt[i]));
        // R4
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_wr_d[i] |=> (st_q.cnt[i] == $past(st_q.cnt[i]) ||
                              st_q.cnt[i] == $past(st_q.cnt[i]) + CNT_W'(1)));
        // R9
        wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_wr_d[i] && !dec.hi) |=> st_q.cnt[i][DATA_W-1:0] == $past(bus_wdata));
        // R2
        sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sel_wr_d[i] |=> $stable(st_q.sel[i]));
    end
endmodule

// File: tb/cpc_bank_bench.sv
module cpc_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [19:0] grp1_ev = '0;
    logic [18:0] grp2_ev = '0;
    logic [13:0] grp3_ev = '0;
    logic [0:0]  grp4_ev = '0;

    typedef struct {
        logic [13:0] addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    logic  rd_seen  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpc_bank u_cpc_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .grp1_ev   (grp1_ev),
        .grp2_ev   (grp2_ev),
        .grp3_ev   (grp3_ev),
        .grp4_ev   (grp4_ev)
    );

    function automatic logic [13:0] sel_a(input int n, input int hi);
        return 14'(14'h2000 + n*8 + hi*4);
    endfunction
    function automatic logic [13:0] cnt_a(input int n, input int hi);
        return 14'(14'h3000 + n*8 + hi*4);
    endfunction

    task automatic bus_wr(input logic [13:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [13:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic ev_pulse(input int g, input logic [19:0] bits, input int n);
        case (g)
            1: grp1_ev = bits;
            2: grp2_ev = bits[18:0];
            3: grp3_ev = bits[13:0];
            default: grp4_ev = bits[0:0];
        endcase
        repeat (n) @(negedge clk);
        grp1_ev = '0; grp2_ev = '0; grp3_ev = '0; grp4_ev = '0;
    endtask

    always @(posedge clk) rd_seen <= bus_en && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: read data with no expected item, actual %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                n_checks++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %h: actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(sel_a(0, 0), 32'h0, "R1 sel0 lo");
        bus_rd(cnt_a(5, 1), 32'h0, "R1 cnt5 hi");
        bus_rd(cnt_a(63, 0), 32'h0, "R1 cnt63 lo");

        // program selectors (R3 encoding)
        bus_wr(sel_a(0, 0), 32'h0000_0801);   // g1 event3
        bus_wr(sel_a(1, 0), 32'h0000_0502);   // g2 events0,2
        bus_wr(sel_a(2, 0), 32'h0000_0104);   // g4 event0
        bus_wr(sel_a(3, 0), 32'h0020_0003);   // g3 event13
        bus_wr(sel_a(4, 0), 32'h1000_0101);   // g1 with event20 (out of range)
        bus_wr(sel_a(5, 0), 32'h0000_0100);   // group 0
        bus_wr(sel_a(6, 0), 32'h0000_0105);   // group 5
        bus_wr(sel_a(8, 0), 32'h0000_8801);   // g1 events3,7
        bus_wr(sel_a(12, 0), 32'h0000_0101);  // g1 event0 ...
        bus_wr(sel_a(12, 1), 32'h0000_0001);  // ... plus event24

        // R2 readback and map
        bus_rd(sel_a(0, 0), 32'h0000_0801, "R2 sel0 lo");
        bus_rd(sel_a(0, 1), 32'h0, "R2 sel0 hi");
        bus_rd(sel_a(12, 1), 32'h0000_0001, "R2 sel12 hi");

        // shared event sequence
        ev_pulse(1, 20'h00008, 5);
        ev_pulse(2, 20'h00005, 4);
        ev_pulse(2, 20'h00002, 3);
        ev_pulse(4, 20'h00001, 2);
        ev_pulse(3, 20'h02000, 3);
        ev_pulse(1, 20'hFFFFF, 2);

        bus_rd(cnt_a(0, 0), 32'd7, "R4 cnt0 g1 single event");
        bus_rd(cnt_a(1, 0), 32'd4, "R4 cnt1 union counts once");
        bus_rd(cnt_a(1, 1), 32'd0, "R7 cnt1 hi");
        bus_rd(cnt_a(2, 0), 32'd2, "R3 cnt2 single-event group");
        bus_rd(cnt_a(3, 0), 32'd3, "R3 cnt3 g3 top event");
        bus_rd(cnt_a(8, 0), 32'd7, "R4 cnt8 two events together");
        bus_rd(cnt_a(4, 0), 32'd0, "R6 cnt4 out-of-range mask");
        bus_rd(cnt_a(12, 0), 32'd0, "R6 cnt12 high mask bit");
        bus_rd(cnt_a(5, 0), 32'd0, "R5 cnt5 group0");
        bus_rd(cnt_a(6, 0), 32'd0, "R5 cnt6 group5");
        bus_rd(cnt_a(7, 0), 32'd0, "R5 cnt7 zero selector");

        // R8 half writes
        bus_wr(cnt_a(0, 1), 32'h0000_ABCD);
        bus_rd(cnt_a(0, 0), 32'd7, "R8 cnt0 lo kept");
        bus_rd(cnt_a(0, 1), 32'h0000_ABCD, "R8 cnt0 hi written");
        bus_wr(cnt_a(0, 0), 32'd0);
        bus_rd(cnt_a(0, 0), 32'd0, "R8 cnt0 lo cleared");
        bus_rd(cnt_a(0, 1), 32'h0000_ABCD, "R8 cnt0 hi kept");

        // R10 wrap and carry
        bus_wr(cnt_a(9, 0), 32'hFFFF_FFFF);
        bus_wr(cnt_a(9, 1), 32'hFFFF_FFFF);
        bus_wr(cnt_a(10, 0), 32'hFFFF_FFFF);
        bus_wr(cnt_a(10, 1), 32'h0000_0005);
        bus_wr(sel_a(9, 0), 32'h0000_0104);
        bus_wr(sel_a(10, 0), 32'h0000_0104);
        ev_pulse(4, 20'h00001, 2);
        bus_rd(cnt_a(9, 0), 32'd1, "R10 cnt9 lo wrapped");
        bus_rd(cnt_a(9, 1), 32'd0, "R10 cnt9 hi wrapped");
        bus_rd(cnt_a(10, 0), 32'd1, "R10 cnt10 lo");
        bus_rd(cnt_a(10, 1), 32'd6, "R10 cnt10 carry");

        // R9 write collides with event
        bus_wr(sel_a(11, 0), 32'h0000_0104);
        grp4_ev = 1'b1;
        bus_wr(cnt_a(11, 0), 32'h0000_0100);
        grp4_ev = 1'b0;
        bus_rd(cnt_a(11, 0), 32'h0000_0100, "R9 write wins");
        ev_pulse(4, 20'h00001, 1);
        bus_rd(cnt_a(11, 0), 32'h0000_0101, "R9 counting resumes");

        // R11 unmapped and misaligned
        bus_wr(14'h2200, 32'h1234_5678);
        bus_wr(14'h3002, 32'h0000_0055);
        bus_rd(14'h2200, 32'h0, "R11 past selector window");
        bus_rd(14'h0000, 32'h0, "R11 low offset");
        bus_rd(14'h2001, 32'h0, "R11 misaligned read");
        bus_rd(14'h3204, 32'h0, "R11 past counter window");
        bus_rd(cnt_a(0, 0), 32'h0, "R11 misaligned write ignored");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule